// File: doc/BRIEF.md
# Half-Rate Transmit Serializer with Bit-Order and Slip Control

This block turns parallel words from a transmit coding layer into a serial bit stream. The word width is a static parameter, either 8 or 10 bits. Each fast-clock cycle the block presents two serial bits. This stands for a clock at half the line rate that launches data on both of its edges. One word therefore occupies `WORD_W/2` fast-clock cycles.

Three transforms can be applied on the way to the serial stream:

- A per-byte flip mirrors the bit order inside the low byte and leaves any bits above it alone.
- A whole-word reversal sends the most significant bit first.
- A bit-slip delays the whole stream by 0 to `WORD_W-1` bit positions. The vacated positions are filled with the tail of the previous word.

All three settings are sampled together with the word, so they take effect at a word boundary.

Before the first word arrives, the block waits with `tx_take` high in every cycle. Once a word with `in_vld` high has been taken, the block runs freely. It samples the next word in the last cycle of every word period. If `in_vld` is low in such a cycle, an all-zero word is sent instead.

Top module: `txser_core`

## Requirements
- R1: After the first accepted word, `tx_take` is high in exactly one cycle out of every `WORD_W/2` cycles. That cycle is the last one of each word period. While idle, `tx_take` is high in every cycle.
- R2: Before the first accepted word, `ser_out` is 00. The first cycle with `in_vld` high is accepted, and the first bit pair of that word appears in the following cycle.
- R3: With no transform and zero slip, the bits are sent LSB first, two per cycle. `ser_out[1]` carries the earlier bit and `ser_out[0]` the later bit, so the first pair is {bit0, bit1} and the last pair is {bit W-2, bit W-1}.
- R4: With `cfg_rev` high, input bit i is sent at position W-1-i, so the MSB is sent first.
- R5: With `cfg_flip` high, bits 7..0 are mirrored (bit i takes input bit 7-i). Bits 9..8 of a 10-bit word are kept unchanged. For example, 8'hAD becomes 8'hB5. The flip is applied before the reversal.
- R6: With slip s, the transmitted word is bits [W-s +: W] of {current shaped word, previous shaped word}. This is the stream delayed by s bits. A slip value above W-1 acts as W-1.
- R7: `cfg_slip`, `cfg_rev` and `cfg_flip` are sampled only in the `tx_take` cycle. Changing them during a word has no effect on that word.
- R8: If `in_vld` is low in a `tx_take` cycle while running, an all-zero word is sent, and that zero word becomes the previous word.
- R9: A synchronous reset drives `ser_out` to 00, clears the previous word and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per bit pair |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Word valid |
| in_word | input | WORD_W | Parallel word |
| cfg_rev | input | 1 | Whole-word reversal enable |
| cfg_flip | input | 1 | Per-byte bit mirror enable |
| cfg_slip | input | $clog2(WORD_W) | Slip in bit positions |
| tx_take | output | 1 | Block samples the inputs in this cycle |
| ser_out | output | 2 | Bit pair, [1] earlier bit, [0] later bit |

## Verification
The assertions check the cadence of `tx_take` on every cycle: it is high every cycle while idle, and high once per word period while running. They also check the quiet idle and reset output. On every accepted word with zero slip, they check the first bit pair for both the plain order and the reversed order.

Some behaviour can only be shown by the bench's scenarios, because it spans several words and depends on the previous word:

- the full bit order inside a word;
- the per-byte flip;
- the slip window and the clamping of large slip values;
- zero fill when no word is offered;
- that settings are ignored in the middle of a word.

The bench shows these by comparing the stream against a bit-queue model, at both widths.

// File: rtl/txser_core.sv
module txser_core #(
  parameter int WORD_W = 10,
  localparam int SLIP_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_word,
  input  logic              cfg_rev,
  input  logic              cfg_flip,
  input  logic [SLIP_W-1:0] cfg_slip,
  output logic              tx_take,
  output logic [1:0]        ser_out
);
  localparam int HALF = WORD_W / 2;
  localparam int PH_W = $clog2(HALF);

  logic              run;
  logic [PH_W-1:0]   ph;
  logic [WORD_W-1:0] shreg, prev;
  logic [WORD_W-1:0] flipped, shaped, w_in, win;
  logic [SLIP_W-1:0] slip_eff;
  logic [SLIP_W:0]   sh_amt;
  logic [2*WORD_W-1:0] cat_sh;
  logic              ld;

  always_comb begin
    flipped = in_word;
    if (cfg_flip)
      for (int i = 0; i < 8; i++)
        if (i < WORD_W) flipped[i] = in_word[7-i];
    shaped = flipped;
    if (cfg_rev)
      for (int i = 0; i < WORD_W; i++) shaped[i] = flipped[WORD_W-1-i];
  end

  assign w_in     = in_vld ? shaped : '0;
  assign slip_eff = (cfg_slip > SLIP_W'(WORD_W-1)) ? SLIP_W'(WORD_W-1) : cfg_slip;
  assign sh_amt   = (SLIP_W+1)'(WORD_W) - {1'b0, slip_eff};
  assign cat_sh   = {w_in, prev} >> sh_amt;
  assign win      = cat_sh[WORD_W-1:0];

  assign tx_take = run ? (ph == PH_W'(HALF-1)) : 1'b1;
  assign ld      = run ? tx_take : in_vld;
  assign ser_out = {shreg[0], shreg[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      ph    <= '0;
      shreg <= '0;
      prev  <= '0;
    end else if (ld) begin
      run   <= 1'b1;
      ph    <= '0;
      shreg <= win;
      prev  <= w_in;
    end else if (run) begin
      ph    <= ph + 1'b1;
      shreg <= shreg >> 2;
    end
  end
endmodule

// File: rtl/txser_core_chk.sv
module txser_core_chk #(
  parameter int WORD_W = 10,
  localparam int SLIP_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [WORD_W-1:0] in_word,
  input logic              cfg_rev,
  input logic              cfg_flip,
  input logic [SLIP_W-1:0] cfg_slip,
  input logic              tx_take,
  input logic [1:0]        ser_out
);
  localparam int HALF = WORD_W / 2;
  localparam int G_W  = $clog2(WORD_W) + 1;

  logic           seen, rst_q;
  logic [G_W-1:0] gap;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      gap <= tx_take ? '0 : gap + 1'b1;
      if (tx_take && in_vld) seen <= 1'b1;
    end
  end

  AST_TAKE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (seen && tx_take) |-> gap == G_W'(HALF-1)); // R1
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !seen |-> tx_take); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !seen |-> ser_out == 2'b00); // R2
  AST_PLAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tx_take && in_vld && cfg_slip == '0 && !cfg_rev && !cfg_flip)
    |=> ser_out == {$past(in_word[0]), $past(in_word[1])}); // R3
  AST_REV_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tx_take && in_vld && cfg_slip == '0 && cfg_rev && !cfg_flip)
    |=> ser_out == {$past(in_word[WORD_W-1]), $past(in_word[WORD_W-2])}); // R4

  always @(posedge clk)
    if (rst_q) AST_RST_QUIET: assert (ser_out == 2'b00); // R9
endmodule

bind txser_core txser_core_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/txser_core_tb_top.sv
module txser_lane #(
  parameter int W = 10,
  parameter int SEED = 1,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          go,
  input  logic          tx_take,
  input  logic [1:0]    ser,
  output logic          rst,
  output logic          vld,
  output logic          rev,
  output logic          flip,
  output logic [SW-1:0] slip,
  output logic [W-1:0]  word,
  output int            errs,
  output int            checks,
  output logic          done
);
  localparam int HALF = W / 2;
  bit q[$];
  int tq[$];
  logic [W-1:0] prev_m;
  int ph_tag, cnt_m;
  bit running_m;

  function automatic logic [W-1:0] fl(input logic [W-1:0] w);
    logic [W-1:0] r = w;
    for (int i = 0; i < 8; i++) r[i] = w[7-i];
    return r;
  endfunction

  function automatic logic [W-1:0] rv(input logic [W-1:0] w);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = w[W-1-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input int tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d W=%0d %s actual=%0h expected=%0h", tag, W, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit r, input bit f,
                     input logic [SW-1:0] s, input logic [W-1:0] w);
    logic [1:0] e;
    int tg;
    logic [W-1:0] sh, wn;
    logic [2*W-1:0] cat;
    int sl;
    @(negedge clk);
    if (q.size() >= 2) begin
      e = {q[0], q[1]}; tg = tq[0];
      void'(q.pop_front()); void'(q.pop_front());
      void'(tq.pop_front()); void'(tq.pop_front());
    end else begin
      e = 2'b00; tg = 2;
    end
    chk(ser == e, tg, "bit pair", int'(ser), int'(e));
    chk(tx_take == (!running_m || cnt_m == HALF-1), 1, "tx_take",
        int'(tx_take), int'(!running_m || cnt_m == HALF-1));
    vld = v; rev = r; flip = f; slip = s; word = w;
    if (tx_take && (v || running_m)) begin
      sh = f ? fl(w) : w;
      if (r) sh = rv(sh);
      if (!v) sh = '0;
      sl = (int'(s) > W-1) ? W-1 : int'(s);
      cat = {sh, prev_m};
      wn = cat[W-sl +: W];
      prev_m = sh;
      if (ph_tag != 0) tg = ph_tag;
      else if (!v) tg = 8;
      else if (s != 0) tg = 6;
      else if (r) tg = 4;
      else if (f) tg = 5;
      else tg = 3;
      for (int i = 0; i < W; i++) begin q.push_back(wn[i]); tq.push_back(tg); end
      running_m = 1; cnt_m = 0;
    end else if (running_m) cnt_m++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; vld = 0;
    repeat (3) begin
      @(negedge clk);
      chk(ser == 2'b00, 9, "ser in reset", int'(ser), 0);
    end
    rst = 0;
    q.delete(); tq.delete();
    prev_m = '0; running_m = 0; cnt_m = 0;
  endtask

  task automatic dir(input bit r, input bit f, input logic [SW-1:0] s,
                     input logic [W-1:0] w, input int tag);
    ph_tag = tag;
    repeat (HALF) cyc(1, r, f, s, w);
    ph_tag = 0;
  endtask

  initial begin
    rst = 1; vld = 0; rev = 0; flip = 0; slip = '0; word = '0;
    errs = 0; checks = 0; done = 0; ph_tag = 0;
    prev_m = '0; running_m = 0; cnt_m = 0;
    void'($urandom(SEED));
    wait (go);
    do_reset();
    repeat (3) cyc(0, 0, 0, '0, '1);                // R2 idle
    dir(0, 0, '0, W'(10'h2B5), 3);                   // R3
    dir(1, 0, '0, W'(10'h1C3), 4);                   // R4
    dir(0, 1, '0, W'(8'hAD), 5);                     // R5
    dir(0, 1, '0, W'(10'h3AD), 5);                   // R5
    dir(0, 0, SW'(W-1), W'(10'h155), 6);             // R6
    dir(0, 0, '1, W'(10'h0F0), 6);                   // R6 clamp
    repeat (HALF) cyc(0, 1, 1, '1, '1);              // R8
    ph_tag = 7;                                      // R7 settings vary each cycle
    repeat (40) cyc(1, 1'($urandom), 1'($urandom), SW'($urandom), W'($urandom));
    ph_tag = 0;
    for (int n = 0; n < 3000; n++)
      cyc(($urandom % 8) != 0, 1'($urandom), 1'($urandom), SW'($urandom), W'($urandom));
    do_reset();                                      // R9
    dir(0, 0, SW'(3), '1, 9);
    dir(0, 0, SW'(3), '0, 9);
    repeat (HALF) cyc(0, 0, 0, '0, '0);
    done = 1;
  end
endmodule

module txser_core_tb_top;
  logic clk = 0;
  always #4 clk = ~clk;

  logic go = 0, wd = 0;
  logic r10, v10, rv10, f10, t10, d10;
  logic [3:0] s10;
  logic [9:0] w10;
  logic [1:0] o10;
  int e10, c10;
  logic r8, v8, rv8, f8, t8, d8;
  logic [2:0] s8;
  logic [7:0] w8;
  logic [1:0] o8;
  int e8, c8;

  txser_core #(.WORD_W(10)) dut_i (.clk(clk), .rst(r10), .in_vld(v10), .in_word(w10),
    .cfg_rev(rv10), .cfg_flip(f10), .cfg_slip(s10), .tx_take(t10), .ser_out(o10));
  txser_lane #(.W(10), .SEED(17)) lane10_i (.clk(clk), .go(go), .tx_take(t10), .ser(o10),
    .rst(r10), .vld(v10), .rev(rv10), .flip(f10), .slip(s10), .word(w10),
    .errs(e10), .checks(c10), .done(d10));

  txser_core #(.WORD_W(8)) dut8_i (.clk(clk), .rst(r8), .in_vld(v8), .in_word(w8),
    .cfg_rev(rv8), .cfg_flip(f8), .cfg_slip(s8), .tx_take(t8), .ser_out(o8));
  txser_lane #(.W(8), .SEED(29)) lane8_i (.clk(clk), .go(go), .tx_take(t8), .ser(o8),
    .rst(r8), .vld(v8), .rev(rv8), .flip(f8), .slip(s8), .word(w8),
    .errs(e8), .checks(c8), .done(d8));

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1;
  end

  initial begin
    int errs, total;
    repeat (2) @(posedge clk);
    go = 1;
    wait ((d10 && d8) || wd);
    errs = e10 + e8;
    total = c10 + c8;
    if (wd) begin
      errs++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule